// File: doc/BRIEF.md
# Data Acquisition Sequencer

This block controls a multi-channel analog input chain. A request picks a channel. The block then steers the external analog multiplexer to that channel and waits a programmable settle time. It puts the sample-and-hold into hold and fires a single start-of-conversion pulse at the converter. It then waits for the converter's end-of-conversion strobe. The multiplexer, the sample-and-hold and the converter are all outside the block.

When the strobe arrives, the converter word is latched and the sample-and-hold goes back to tracking. A done flag marks the result as valid. The CPU reads the result through external three-state gates. The block raises their enable only while the CPU read strobe is active and a valid result is held. If the converter never answers, a watchdog raises an error flag and the block returns to idle.

In scan mode, finishing each CPU read moves the channel index on by one, wrapping at the last channel, and starts the next conversion by itself. The CPU only has to keep reading.

Top module: `daq_sequencer`

## Requirements
- R1: While and after reset, with no request, `busy_o`, `hold_o`, `soc_o`, `bus_oe_o`, `done_o` and `err_o` are low and `mux_sel_o` is 0.
- R2: A request accepted in idle updates `mux_sel_o` one cycle later. The new value is `chan_i`, or the scan index when `scan_en_i` is high. It stays stable until the sequencer is idle again.
- R3: With S the value of `settle_cycles_i` sampled with the request, `hold_o` rises S+1 cycles after `mux_sel_o` changes.
- R4: `soc_o` is a pulse exactly one cycle wide. It is issued in the cycle after `hold_o` first goes high, and `hold_o` stays high during it.
- R5: `hold_o` stays high until `eoc_i` is sampled high while waiting. The cycle after that, `hold_o` is low, `busy_o` is low, `done_o` is high and the result holds the `adc_data_i` value sampled with `eoc_i`.
- R6: `bus_oe_o` is high exactly when `rd_i` is high and `done_o` is high. While it is high, `bus_data_o` carries the latched result.
- R7: The wait for `eoc_i` lasts at most TIMEOUT cycles after the `soc_o` pulse. If `eoc_i` is not sampled high in any of those cycles, `err_o` goes high, `hold_o` drops and the block returns to idle with `done_o` low. The next accepted start clears `err_o` and `done_o`.
- R8: `req_i` while `busy_o` is high is ignored: the channel, timing and result of the running conversion are unchanged.
- R9: In scan mode, `rd_i` falling while `done_o` is high advances the scan index by one. The index wraps from NUM_CH-1 to 0. A new conversion on that channel starts in the same cycle, as if requested. The scan index is 0 after reset.
- R10: With `scan_en_i` low, reading has no effect on `mux_sel_o` or `done_o` and starts nothing.
- R11: `eoc_i` while idle, settling, holding or pulsing start is ignored: it neither latches data nor ends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request one acquisition |
| chan_i | input | CH_W | Channel for a request outside scan mode |
| scan_en_i | input | 1 | Scan mode enable |
| settle_cycles_i | input | SETTLE_W | Settle delay, sampled with the request |
| mux_sel_o | output | CH_W | Analog multiplexer select |
| hold_o | output | 1 | Sample-and-hold in hold mode when high |
| soc_o | output | 1 | Start-of-conversion pulse |
| eoc_i | input | 1 | End-of-conversion strobe from the converter |
| adc_data_i | input | DATA_W | Converter output word |
| rd_i | input | 1 | CPU read strobe |
| bus_oe_o | output | 1 | Three-state gate enable onto the CPU bus |
| bus_data_o | output | DATA_W | Latched result toward the gates |
| done_o | output | 1 | A valid result is latched |
| err_o | output | 1 | Converter timeout occurred |
| busy_o | output | 1 | Acquisition in progress |

## Verification
Single requests are issued with settle values of 0, 2 and 7 and converter latencies from 1 cycle up to the last accepted one. This separates off-by-one errors in the settle count from errors in the hold-to-start spacing. A latency equal to TIMEOUT, and a converter that stays silent, separate the last accepted strobe from the first expiry. A second request during settling and stray end-of-conversion pulses outside the wait show whether inputs are wrongly accepted. Reads with scan mode off and on, over more than one full channel cycle, show whether the index advances only on completed reads and wraps to channel 0.

// File: rtl/daq_pkg.sv
package daq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HOLD,
    ST_SOC,
    ST_WAIT
  } daq_state_e;
endpackage

// File: rtl/daq_settle_timer.sv
module daq_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= value_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3
  settle_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(value_i)));
endmodule

// File: rtl/daq_watchdog.sv
module daq_watchdog #(
  parameter int LIMIT = 64,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // R7
  wdg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!expire_o || LIMIT == 1));
endmodule

// File: rtl/daq_result_port.sv
module daq_result_port #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bus_oe_o,
  output logic              read_done_o
);
  logic              valid_q, rd_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (clear_i)        valid_q <= 1'b0;
      else if (capture_i) valid_q <= 1'b1;
      if (capture_i)      data_q  <= data_i;
    end
  end

  assign valid_o     = valid_q;
  assign data_o      = data_q;
  assign bus_oe_o    = rd_i && valid_q;
  // read completes on the trailing edge of the strobe
  assign read_done_o = valid_q && rd_q && !rd_i;

  // R5
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !clear_i) |=> (valid_o && data_o == $past(data_i)));
  // R6
  oe_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (valid_o && $stable(data_o)));
endmodule

// File: rtl/daq_sequencer.sv
module daq_sequencer
  import daq_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int NUM_CH   = 8,
  parameter int SETTLE_W = 8,
  parameter int TIMEOUT  = 64,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                scan_en_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic [CH_W-1:0]     mux_sel_o,
  output logic                hold_o,
  output logic                soc_o,
  input  logic                eoc_i,
  input  logic [DATA_W-1:0]   adc_data_i,
  input  logic                rd_i,
  output logic                bus_oe_o,
  output logic [DATA_W-1:0]   bus_data_o,
  output logic                done_o,
  output logic                err_o,
  output logic                busy_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  daq_state_e      state_q, state_d;
  logic [CH_W-1:0] mux_q, scan_idx_q, next_idx, start_ch;
  logic            err_q;
  logic            start, settle_done, wd_expire, read_done, capture;

  assign next_idx = (scan_idx_q == LAST_CH) ? '0 : scan_idx_q + 1'b1;
  assign start    = (state_q == ST_IDLE) && (req_i || (scan_en_i && read_done));
  assign start_ch = req_i ? (scan_en_i ? scan_idx_q : chan_i) : next_idx;
  assign capture  = (state_q == ST_WAIT) && eoc_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_SOC;
      ST_SOC:    state_d = ST_WAIT;
      ST_WAIT:   if (eoc_i || wd_expire) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mux_q      <= '0;
      scan_idx_q <= '0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) mux_q <= start_ch;
      if (start && !req_i) scan_idx_q <= next_idx;
      if (start) err_q <= 1'b0;
      else if ((state_q == ST_WAIT) && !eoc_i && wd_expire) err_q <= 1'b1;
    end
  end

  daq_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .value_i (settle_cycles_i),
    .run_i   (state_q == ST_SETTLE),
    .done_o  (settle_done)
  );

  daq_watchdog #(.LIMIT(TIMEOUT)) u_wdg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q == ST_SOC),
    .run_i    (state_q == ST_WAIT),
    .expire_o (wd_expire)
  );

  daq_result_port #(.DATA_W(DATA_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start),
    .capture_i   (capture),
    .data_i      (adc_data_i),
    .rd_i        (rd_i),
    .valid_o     (done_o),
    .data_o      (bus_data_o),
    .bus_oe_o    (bus_oe_o),
    .read_done_o (read_done)
  );

  assign mux_sel_o = mux_q;
  assign hold_o    = (state_q == ST_HOLD) || (state_q == ST_SOC) || (state_q == ST_WAIT);
  assign soc_o     = (state_q == ST_SOC);
  assign busy_o    = (state_q != ST_IDLE);
  assign err_o     = err_q;

  // R4
  soc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o |=> !soc_o);
  // R4
  soc_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o |-> ($past(hold_o) && hold_o));
  // R5
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> (!hold_o && done_o && !busy_o));
  // R2
  mux_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));
  // R9
  scan_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !req_i && scan_idx_q == LAST_CH) |=> (mux_sel_o == '0));
endmodule

// File: tb/daq_sequencer_test.sv
`timescale 1ns/1ps
module daq_sequencer_test;
  localparam int DATA_W = 10, NUM_CH = 8, SETTLE_W = 6, TIMEOUT = 24;
  localparam int CH_W = $clog2(NUM_CH);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                req = 0, scan_en = 0, rd = 0, stray_eoc = 0;
  logic [CH_W-1:0]     chan = 0;
  logic [SETTLE_W-1:0] settle = 0;
  logic [CH_W-1:0]     mux_sel;
  logic                hold, soc, bus_oe, done, err, busy;
  logic [DATA_W-1:0]   bus_data;
  logic                conv_eoc = 0;
  logic [DATA_W-1:0]   conv_data = 0;
  wire                 eoc = conv_eoc | stray_eoc;

  int errors = 0, checks = 0;
  int conv_lat = 4;
  bit conv_mute = 0;
  bit cmp_on = 0;

  daq_sequencer #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .SETTLE_W(SETTLE_W), .TIMEOUT(TIMEOUT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chan_i(chan), .scan_en_i(scan_en),
    .settle_cycles_i(settle), .mux_sel_o(mux_sel), .hold_o(hold), .soc_o(soc),
    .eoc_i(eoc), .adc_data_i(conv_data), .rd_i(rd), .bus_oe_o(bus_oe),
    .bus_data_o(bus_data), .done_o(done), .err_o(err), .busy_o(busy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural converter: answers conv_lat cycles after the start pulse
  int conv_cnt = 0, conv_seq = 0, conv_ch = 0;
  always @(posedge clk) begin
    conv_eoc <= 1'b0;
    if (soc) begin
      conv_cnt = conv_lat;
      conv_ch  = int'(mux_sel);
    end else if (conv_cnt > 0) begin
      conv_cnt--;
      if (conv_cnt == 0 && !conv_mute) begin
        conv_eoc  <= 1'b1;
        conv_data <= DATA_W'((conv_ch * 97 + conv_seq * 29 + 11) % 1024);
        conv_seq++;
      end
    end
  end

  // reference model: phase 0 idle, 1 settle, 2 hold, 3 start, 4 wait
  int m_phase = 0, m_cnt = 0, m_wait = 0, m_mux = 0, m_idx = 0, m_data = 0;
  bit m_valid = 0, m_err = 0, m_rdq = 0;

  task automatic m_start(input int ch);
    m_mux = ch; m_valid = 0; m_err = 0; m_cnt = int'(settle); m_phase = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_wait = 0; m_mux = 0; m_idx = 0;
      m_data = 0; m_valid = 0; m_err = 0; m_rdq = 0;
    end else begin
      case (m_phase)
        0: if (req) m_start(scan_en ? m_idx : int'(chan));
           else if (scan_en && m_valid && m_rdq && !rd) begin
             m_idx = (m_idx + 1) % NUM_CH;
             m_start(m_idx);
           end
        1: if (m_cnt == 0) m_phase = 2; else m_cnt--;
        2: m_phase = 3;
        3: begin m_phase = 4; m_wait = 0; end
        default: if (eoc) begin
             m_data = int'(conv_data); m_valid = 1; m_phase = 0;
           end else if (m_wait == TIMEOUT - 1) begin
             m_err = 1; m_phase = 0;
           end else m_wait++;
      endcase
      m_rdq = rd;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      check(int'(mux_sel) == m_mux, "R2 mux_sel", int'(mux_sel), m_mux);
      check(hold == (m_phase >= 2), "R3/R5 hold", hold, m_phase >= 2);
      check(soc == (m_phase == 3), "R4 soc", soc, m_phase == 3);
      check(busy == (m_phase != 0), "R8 busy", busy, m_phase != 0);
      check(done == m_valid, "R5 done", done, m_valid);
      check(err == m_err, "R7 err", err, m_err);
      check(bus_oe == (rd && m_valid), "R6 bus_oe", bus_oe, rd && m_valid);
      if (bus_oe && m_valid)
        check(int'(bus_data) == m_data, "R6 bus_data", int'(bus_data), m_data);
    end
  end

  // converter must see hold while it converts
  always @(negedge clk) begin
    #1;
    if (cmp_on && conv_cnt > 0)
      check(hold, "R5 hold during conversion", hold, 1);
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic read_result();
    @(negedge clk); rd = 1;
    @(negedge clk);
    @(negedge clk); rd = 0;
  endtask

  // single request with explicit timing checks on settle, hold and start pulse
  task automatic single(input int ch, input int s, input int lat);
    @(negedge clk);
    chan = CH_W'(ch); settle = SETTLE_W'(s); conv_lat = lat; req = 1;
    @(negedge clk); req = 0; #1;
    check(int'(mux_sel) == ch, "R2 mux after request", int'(mux_sel), ch);
    for (int i = 0; i < s; i++) begin
      @(negedge clk); #1;
    end
    check(!hold, "R3 hold low at S cycles", hold, 0);
    @(negedge clk); #1;
    check(hold, "R3 hold high at S+1 cycles", hold, 1);
    check(!soc, "R4 no soc in first hold cycle", soc, 0);
    @(negedge clk); #1;
    check(soc, "R4 soc one cycle after hold", soc, 1);
    @(negedge clk); #1;
    check(!soc && hold, "R4 soc single cycle", soc, 0);
    wait_idle();
  endtask

  initial begin
    #1;
    check(!busy && !hold && !soc && !bus_oe && !done && !err && mux_sel == 0,
          "R1 state during reset", int'(busy) + int'(hold) + int'(done), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(!busy && !hold && !soc && !bus_oe && !done && !err && mux_sel == 0,
          "R1 state after reset", int'(busy) + int'(hold) + int'(done), 0);
    cmp_on = 1;

    single(3, 0, 4);
    check(done && !err, "R5 done after first conversion", done, 1);
    read_result();
    single(5, 7, 1);
    read_result();
    check(done && mux_sel == 5, "R10 read without scan changes nothing", int'(mux_sel), 5);
    repeat (3) @(negedge clk); #1;
    check(!busy, "R10 no restart without scan", busy, 0);

    // request during settling must be ignored
    @(negedge clk); chan = 2; settle = 5; conv_lat = 3; req = 1;
    @(negedge clk); req = 0; chan = 6;
    @(negedge clk); req = 1;
    @(negedge clk); req = 0; #1;
    check(mux_sel == 2, "R8 second request ignored", int'(mux_sel), 2);
    // stray end-of-conversion during settling
    @(negedge clk); stray_eoc = 1;
    @(negedge clk); stray_eoc = 0; #1;
    check(busy && !done, "R11 stray eoc in settle ignored", done, 0);
    wait_idle();
    check(mux_sel == 2 && done, "R8 running conversion kept", int'(mux_sel), 2);

    // stray end-of-conversion while idle
    @(negedge clk); stray_eoc = 1;
    @(negedge clk); stray_eoc = 0; #1;
    check(!busy && done, "R11 stray eoc in idle ignored", busy, 0);

    // last accepted latency, then first expired one
    single(1, 2, TIMEOUT - 1);
    check(done && !err, "R7 answer at last wait cycle accepted", err, 0);
    single(4, 0, TIMEOUT);
    check(err && !done && !hold, "R7 timeout at TIMEOUT", err, 1);
    conv_mute = 1;
    single(7, 1, 3);
    check(err && !done, "R7 silent converter", err, 1);
    conv_mute = 0;
    single(0, 2, 9);
    check(!err && done, "R7 next start clears error", err, 0);

    // scan mode over more than one channel cycle
    scan_en = 1;
    @(negedge clk); settle = 1; conv_lat = 2; req = 1;
    @(negedge clk); req = 0; #1;
    check(mux_sel == 0, "R9 scan starts at index 0", int'(mux_sel), 0);
    for (int k = 0; k < 10; k++) begin
      wait_idle();
      @(negedge clk); rd = 1;
      @(negedge clk); rd = 0;
      @(negedge clk); #1;
      check(int'(mux_sel) == (k + 1) % NUM_CH && busy, "R9 scan index advance",
            int'(mux_sel), (k + 1) % NUM_CH);
    end
    scan_en = 0;
    wait_idle();
    read_result();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule